// File: doc/BRIEF.md
# Far-End Alarm Code Receiver

This block listens to the far-end alarm and control bit of each incoming DS3 frame. The bits arrive as a serial stream, one per frame, and a valid strobe marks each one. The receiver hunts for an 8-bit alignment flag. It captures the 6-bit code word that comes straight after the flag, then goes back to hunting. The last ten captured code words are kept in a sliding history.

A code is declared validated when at least eight of the ten stored messages carry it. A validated code is declared removed when at least three of the ten stored messages carry some other code. Each event sets a sticky status bit, and each status bit has its own interrupt enable. A small register port lets a host enable the interrupts, read and clear the status, and read the validated code.

Top module: `farend_code_rx`

## Requirements
- R1: While hunting, the receiver finds the alignment flag when the last eight accepted bits, oldest first, are 0,1,1,1,1,1,1,0. Any other 8-bit run, such as 0,1,1,1,1,1,1,1, starts no capture.
- R2: The six accepted bits right after the flag form the code word, with the first of them as the most significant bit. After the sixth bit the receiver hunts again from a cleared flag search. Bits presented while `fa_vld_i` is low are ignored.
- R3: When no code is validated and a newly stored code word appears in at least 8 of the last 10 stored messages, the block does three things: it sets the validated flag, loads the code into the code register, and sets the validation status. All three are visible after the second rising edge that follows the cycle in which the last code bit was presented.
- R4: While a code is validated, once at least 3 of the last 10 stored messages hold a different code, the validated flag clears and the removal status sets, with the same timing as R3.
- R5: While the same code stays validated, further matching messages leave the code register unchanged and set no new validation status.
- R6: Register 0 reads as {3'b0, validated, val_en, val_status, rem_en, rem_status}. A write to register 0 loads val_en from bit 3 and rem_en from bit 1, so writing 8'b0000_1010 enables both interrupts. Register 1 reads the validated code in bits 5:0.
- R7: The status bits are sticky. A read of register 0 clears them, and a new event in the same cycle takes priority over the clear.
- R8: `irq_o` is high exactly when an enabled status bit is set.
- R9: Reset empties the history and clears the validated flag, the code register, both status bits and both enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fa_bit_i | input | 1 | Serial alarm-channel bit |
| fa_vld_i | input | 1 | Qualifies `fa_bit_i` for one cycle |
| reg_addr_i | input | 1 | Register select |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears status on register 0) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from `reg_addr_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench drives each bit at a falling edge, and the bit is accepted at the next rising edge. Storing a code into the history takes one register stage and the vote takes a second, so the flag, the code and the status are read one full cycle after the edge that accepted the last code bit. Read data and `irq_o` are combinational from the state, so the bench samples them one time unit after setting the address at a falling edge. The status clear lands on the following rising edge, and the bench's model clears its own copy of the status at that same point.

// File: rtl/farend_code_rx.sv
module farend_code_rx #(
  parameter int          CODE_W = 6,
  parameter int          DEPTH  = 10,
  parameter int          VAL_TH = 8,
  parameter int          REM_TH = 3,
  parameter logic [7:0]  FLAG   = 8'h7E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fa_bit_i,
  input  logic       fa_vld_i,
  input  logic       reg_addr_i,
  input  logic       reg_wr_i,
  input  logic       reg_rd_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       irq_o
);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int BW  = $clog2(CODE_W + 1);

  logic [7:0]        srch;
  logic              cap;
  logic [BW-1:0]     cnt;
  logic [CODE_W-1:0] cw;
  logic [CODE_W-1:0] hist [DEPTH];
  logic [DEPTH-1:0]  hval;
  logic              eval_q;
  logic              valid_q;
  logic [CODE_W-1:0] vcode;
  logic              en_val, en_rem, st_val, st_rem;
  logic [CW-1:0]     same_cnt, diff_cnt;
  logic              do_val, do_rem, last_bit, rd_clr;
  logic [CODE_W-1:0] new_code;
  logic [7:0]        next_srch;

  wire unused_wdata = ^{reg_wdata_i[7:4], reg_wdata_i[2], reg_wdata_i[0]};

  assign next_srch = {srch[6:0], fa_bit_i};
  assign last_bit  = fa_vld_i && cap && (cnt == BW'(CODE_W - 1));
  assign new_code  = {cw[CODE_W-2:0], fa_bit_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srch <= '0;
      cap  <= 1'b0;
      cnt  <= '0;
      cw   <= '0;
    end else if (fa_vld_i) begin
      if (!cap) begin
        if (next_srch == FLAG) begin
          cap  <= 1'b1;
          cnt  <= '0;
          srch <= '0;
        end else begin
          srch <= next_srch;
        end
      end else begin
        cw  <= new_code;
        cnt <= cnt + BW'(1);
        if (last_bit) cap <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_hist
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hist[i] <= '0;
        hval[i] <= 1'b0;
      end else if (last_bit) begin
        if (i == 0) begin
          hist[i] <= new_code;
          hval[i] <= 1'b1;
        end else begin
          hist[i] <= hist[i-1];
          hval[i] <= hval[i-1];
        end
      end
    end
  end

  always_comb begin
    same_cnt = '0;
    diff_cnt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hval[i] && hist[i] == hist[0]) same_cnt = same_cnt + CW'(1);
      if (hval[i] && hist[i] != vcode)   diff_cnt = diff_cnt + CW'(1);
    end
  end

  assign do_rem = eval_q && valid_q && (diff_cnt >= CW'(REM_TH));
  assign do_val = eval_q && !valid_q && hval[0] && (same_cnt >= CW'(VAL_TH));
  assign rd_clr = reg_rd_i && !reg_addr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eval_q  <= 1'b0;
      valid_q <= 1'b0;
      vcode   <= '0;
      en_val  <= 1'b0;
      en_rem  <= 1'b0;
      st_val  <= 1'b0;
      st_rem  <= 1'b0;
    end else begin
      eval_q <= last_bit;
      if (do_rem) valid_q <= 1'b0;
      else if (do_val) begin
        valid_q <= 1'b1;
        vcode   <= hist[0];
      end
      if (do_val)      st_val <= 1'b1;
      else if (rd_clr) st_val <= 1'b0;
      if (do_rem)      st_rem <= 1'b1;
      else if (rd_clr) st_rem <= 1'b0;
      if (reg_wr_i && !reg_addr_i) begin
        en_val <= reg_wdata_i[3];
        en_rem <= reg_wdata_i[1];
      end
    end
  end

  assign reg_rdata_o = reg_addr_i ? {{(8-CODE_W){1'b0}}, vcode}
                                  : {3'b000, valid_q, en_val, st_val, en_rem, st_rem};
  assign irq_o = (st_val && en_val) || (st_rem && en_rem);

  AST_CAP_RANGE:  assert property (@(posedge clk) disable iff (!rst_n) cap |-> cnt < BW'(CODE_W)); // R2
  AST_VAL_CAUSE:  assert property (@(posedge clk) disable iff (!rst_n) $rose(valid_q) |-> $past(eval_q) && st_val); // R3
  AST_REM_FLAG:   assert property (@(posedge clk) disable iff (!rst_n) $fell(valid_q) |-> st_rem); // R4
  AST_CODE_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) valid_q && $past(valid_q) |-> $stable(vcode)); // R5
  AST_IRQ_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) (!en_val && !en_rem) |-> !irq_o); // R8
endmodule

// File: tb/farend_code_rx_bench.sv
module farend_code_rx_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fa_bit_i = 1'b0, fa_vld_i = 1'b0;
  logic       reg_addr_i = 1'b0, reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       irq_o;

  int checks = 0, errors = 0;

  // reference model state
  logic [7:0] m_srch;
  bit         m_cap;
  int         m_cnt;
  logic [5:0] m_cw;
  logic [5:0] m_hist [10];
  bit         m_hval [10];
  bit         m_valid, m_ven, m_ren, m_sval, m_srem;
  logic [5:0] m_code;

  farend_code_rx u_farend_code_rx (
    .clk(clk), .rst_n(rst_n), .fa_bit_i(fa_bit_i), .fa_vld_i(fa_vld_i),
    .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic void m_reset();
    m_srch = '0; m_cap = 0; m_cnt = 0; m_cw = '0;
    for (int i = 0; i < 10; i++) begin m_hist[i] = '0; m_hval[i] = 0; end
    m_valid = 0; m_ven = 0; m_ren = 0; m_sval = 0; m_srem = 0; m_code = '0;
  endfunction

  function automatic void m_vote();
    int same = 0, diff = 0;
    for (int i = 0; i < 10; i++) begin
      if (m_hval[i] && m_hist[i] == m_hist[0]) same++;
      if (m_hval[i] && m_hist[i] != m_code) diff++;
    end
    if (m_valid) begin
      if (diff >= 3) begin m_valid = 0; m_srem = 1; end
    end else if (same >= 8) begin
      m_valid = 1; m_code = m_hist[0]; m_sval = 1;
    end
  endfunction

  function automatic void m_bit(input logic b);
    if (!m_cap) begin
      m_srch = {m_srch[6:0], b};
      if (m_srch == 8'b0111_1110) begin m_cap = 1; m_cnt = 0; m_srch = '0; end
    end else begin
      m_cw = {m_cw[4:0], b};
      m_cnt++;
      if (m_cnt == 6) begin
        m_cap = 0;
        for (int i = 9; i > 0; i--) begin m_hist[i] = m_hist[i-1]; m_hval[i] = m_hval[i-1]; end
        m_hist[0] = m_cw; m_hval[0] = 1;
        m_vote();
      end
    end
  endfunction

  // called at a falling edge, returns at a falling edge
  task automatic put_bit(input logic b);
    int gap = $urandom_range(0, 2);
    repeat (gap) begin
      fa_bit_i = 1'($urandom);
      @(negedge clk);
    end
    fa_bit_i = b; fa_vld_i = 1'b1;
    @(posedge clk);
    m_bit(b);
    @(negedge clk);
    fa_vld_i = 1'b0;
  endtask

  task automatic send_msg(input logic [5:0] code);
    logic [7:0] flag = 8'b0111_1110;
    for (int i = 7; i >= 0; i--) put_bit(flag[i]);
    for (int i = 5; i >= 0; i--) put_bit(code[i]);
  endtask

  task automatic write0(input logic [7:0] d);
    reg_addr_i = 1'b0; reg_wdata_i = d; reg_wr_i = 1'b1;
    @(posedge clk);
    m_ven = d[3]; m_ren = d[1];
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  // one settling cycle, then compare irq, code and status (status read clears)
  task automatic check_all(input string req);
    @(posedge clk); @(negedge clk);
    #1;
    check({req, "/R8 irq"}, int'(irq_o), int'((m_sval && m_ven) || (m_srem && m_ren)));
    reg_addr_i = 1'b1; #1;
    check({req, "/R6 code"}, int'(reg_rdata_o), int'(m_code));
    reg_addr_i = 1'b0; reg_rd_i = 1'b1; #1;
    check({req, "/R7 status"}, int'(reg_rdata_o),
          int'({3'b000, m_valid, m_ven, m_sval, m_ren, m_srem}));
    @(posedge clk);
    m_sval = 0; m_srem = 0;
    @(negedge clk);
    reg_rd_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R9 reset");

    write0(8'b1111_1010);
    check_all("R6 enable write");

    // R1 near miss: 0111_1111 then a 6-bit tail, no capture may follow
    begin
      logic [13:0] nm = 14'b01111111_000000;
      for (int i = 13; i >= 0; i--) put_bit(nm[i]);
    end
    // R2 flag presented with valid low must be ignored
    begin
      logic [7:0] f = 8'b0111_1110;
      for (int i = 7; i >= 0; i--) begin fa_bit_i = f[i]; @(negedge clk); end
    end
    check_all("R1 R2 near miss");

    for (int k = 1; k <= 7; k++) begin
      send_msg(6'h2D);
      check_all("R3 below threshold");
    end
    send_msg(6'h2D);
    check_all("R3 eighth match validates");
    check("R3 flag", int'(m_valid), 1);

    repeat (2) begin
      send_msg(6'h2D);
      check_all("R5 hold");
    end

    send_msg(6'h15); check_all("R4 one other");
    send_msg(6'h15); check_all("R4 two other");
    send_msg(6'h15); check_all("R4 third other removes");
    check("R4 flag", int'(m_valid), 0);

    for (int k = 0; k < 120; k++) begin
      int sel = $urandom_range(0, 9);
      logic [5:0] c = (sel < 5) ? 6'h2D : (sel < 8) ? 6'h15 : 6'($urandom);
      if ($urandom_range(0, 15) == 0) write0(8'($urandom));
      send_msg(c);
      check_all("R3 R4 R5 random");
    end

    rst_n = 1'b0;
    m_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R9 mid-run reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule